// File: doc/BRIEF.md
# Parallel Port Mode and Pin Control

This block is the register-driven control core of a host-side IEEE-1284 style parallel port. Software writes a configuration word that requests an operating mode, a data/control word that sets the data byte and five software control bits, and a control-only word that changes the five control bits without touching the data byte. The block works out the effective four-bit mode, holds a requested change back until the external handshake engine reports idle (unless the request carries a force bit), and drives the four active-low control pins and the data output enable from either software or the handshake engine, depending on the mode. Every output pin and every status input has its own polarity-inversion bit.

The five status inputs are inverted as programmed and returned in a status word together with the effective mode, a flag for an illegal mode request, the pending peripheral interrupt and a flag that shows a mode change is still waiting. A peripheral-interrupt latch is set by a one-cycle event from the peripheral side and is cleared by software through an acknowledge bit. Clearing the enable bit of the configuration word holds the port logic in its reset state; the configuration word itself stays writeable.

Top module: `lpt_ctl_core`

## Requirements
- R1: On synchronous reset, and in every cycle that follows a cycle in which the enable bit (configuration bit 5) is 0, the effective mode is manual (0), the data byte and software control bits are 0 and the interrupt latch is clear; the configuration word is cleared only by reset.
- R2: The requested mode is {extension bit (config bit 3), mode field (config bits 2:0)}; legal values are 0 to 7 (manual, centronics, fastbyte, nibble, byte, ecp forward, ecp reverse, off) and, with the extension bit set, 8 (epp read), 13, 14 and 15 (epp write variants 1 to 3).
- R3: With the force bit (config bit 4) clear, a legal request different from the effective mode is adopted at the first clock edge at which hs_idle is 1, one cycle after the write at the earliest; while hs_idle is 0 the effective mode does not change.
- R4: With the force bit set, a legal request is adopted at the next clock edge regardless of hs_idle.
- R5: A request with the extension bit set and mode field 1 to 4 sets the illegal flag (status bit 9) and is never adopted; the effective mode always holds a legal value.
- R6: In manual mode each active-low pin is low when its software bit is 1 and its output-invert bit is 0, and the opposite level when the invert bit is 1; data_oe equals the software oe bit XOR its invert bit. Control vector order is {oe, selectin, autofd, strobe, init}, written at bits 12:8 of address 0, bits 4:0 of address 1, and its invert bits at config bits 10:6.
- R7: In off mode (7) selectin_n is 0 and autofd_n, strobe_n and init_n are 1 whatever the invert bits; data_oe is at its inactive level, equal to its invert bit.
- R8: In the other modes the handshake-engine request hs_ctl (same bit order) drives a pin, except that software keeps init in centronics, fastbyte, nibble and byte modes and keeps autofd in centronics and fastbyte modes; inversion applies as in manual mode.
- R9: Status bits 4:0 are {perror, ack_n, busy, fault_n, select}, each XORed with its input-invert bit at config bits 15:11 in the same order.
- R10: A periph_evt pulse sets the interrupt latch (peri_irq, status bit 10); a write to address 0 with bit 16 set clears it, a write with bit 16 clear leaves it, and an event in the same cycle as an acknowledge wins.
- R11: A write to address 1 updates only the software control bits; the data byte keeps its value. Address 3 is ignored.
- R12: Status bits 8:5 show the effective mode, not the requested one, and status bit 11 is set while a legal request differs from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 data and control, 1 control only, 2 configuration |
| wr_data | input | 32 | Write data |
| hs_idle | input | 1 | Handshake engine is idle |
| hs_ctl | input | 5 | Handshake engine pin requests {oe, selectin, autofd, strobe, init}, active high |
| periph_evt | input | 1 | Peripheral interrupt event pulse |
| perror | input | 1 | Paper-error status pin |
| ack_n | input | 1 | Acknowledge status pin |
| busy | input | 1 | Busy status pin |
| fault_n | input | 1 | Fault status pin |
| select | input | 1 | Select status pin |
| data_out | output | 8 | Software data byte |
| data_oe | output | 1 | Data buffer output enable |
| strobe_n | output | 1 | Strobe pin |
| autofd_n | output | 1 | Auto-feed pin |
| init_n | output | 1 | Initialise pin |
| selectin_n | output | 1 | Select-in pin |
| peri_irq | output | 1 | Pending peripheral interrupt |
| status_word | output | 16 | Status word |

## Verification
The assertions assume that hs_idle, hs_ctl and periph_evt are synchronous to clk and may take any value in any cycle, and that the handshake engine never needs the port to stay in a mode the software has left; the deferral and force properties therefore hold for any idle pattern. The stimulus changes every input half a cycle away from the active edge, holds hs_idle low across whole windows to exercise deferral, and only uses addresses 0 to 2 with the field positions listed in the requirements.

// File: rtl/lpt_pkg.sv
package lpt_pkg;

    localparam int CTL_W  = 5;
    localparam int STS_W  = 5;
    localparam int MODE_W = 4;
    localparam int CFG_W  = 16;

    localparam logic [MODE_W-1:0] MODE_MANUAL = 4'd0;
    localparam logic [MODE_W-1:0] MODE_CENTR  = 4'd1;
    localparam logic [MODE_W-1:0] MODE_FAST   = 4'd2;
    localparam logic [MODE_W-1:0] MODE_NIBBLE = 4'd3;
    localparam logic [MODE_W-1:0] MODE_BYTE   = 4'd4;
    localparam logic [MODE_W-1:0] MODE_OFF    = 4'd7;

    localparam logic [1:0] ADR_DATA_CTL = 2'd0;
    localparam logic [1:0] ADR_CTL_ONLY = 2'd1;
    localparam logic [1:0] ADR_CONFIG   = 2'd2;

    // Control vector, bit 4 down to bit 0.
    typedef struct packed {
        logic oe;
        logic slin;
        logic afd;
        logic stb;
        logic ini;
    } ctl_t;

    // Status vector, bit 4 down to bit 0.
    typedef struct packed {
        logic perr;
        logic ackn;
        logic bsy;
        logic flt;
        logic slct;
    } sts_t;

    typedef struct packed {
        sts_t       in_inv;
        ctl_t       out_inv;
        logic       en;
        logic       force_sw;
        logic       ext;
        logic [2:0] mode;
    } cfg_t;

    function automatic logic mode_legal(input logic [MODE_W-1:0] m);
        return !m[3] || (m[2:0] == 3'd0) || (m[2:0] >= 3'd5);
    endfunction

    // Pins that software keeps in a given mode (1 = software owns).
    function automatic logic [CTL_W-1:0] sw_owned(input logic [MODE_W-1:0] m);
        logic [CTL_W-1:0] own;
        case (m)
            MODE_MANUAL:            own = 5'b11111;
            MODE_CENTR, MODE_FAST:  own = 5'b00101;
            MODE_NIBBLE, MODE_BYTE: own = 5'b00001;
            default:                own = 5'b00000;
        endcase
        return own;
    endfunction

endpackage

// File: rtl/lpt_regs.sv
module lpt_regs
    import lpt_pkg::*;
#(
    parameter int BUS_W   = 32,
    parameter int DATA_W  = 8,
    parameter int ADDR_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BUS_W-1:0]  wr_data,
    input  logic              periph_evt,
    output cfg_t              cfg_q,
    output ctl_t              sw_ctl_q,
    output logic [DATA_W-1:0] data_q,
    output logic              irq_q
);
    localparam int CTL_LSB = DATA_W;
    localparam int ACK_POS = 2 * DATA_W;

    logic port_clr;
    logic wr_dc, wr_co, wr_cf;

    assign port_clr = rst || !cfg_q.en;
    assign wr_dc = wr_en && (wr_addr == ADDR_W'(ADR_DATA_CTL));
    assign wr_co = wr_en && (wr_addr == ADDR_W'(ADR_CTL_ONLY));
    assign wr_cf = wr_en && (wr_addr == ADDR_W'(ADR_CONFIG));

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_cf) begin
            cfg_q <= cfg_t'(wr_data[CFG_W-1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (port_clr) begin
            sw_ctl_q <= '0;
            data_q   <= '0;
        end else if (wr_dc) begin
            sw_ctl_q <= ctl_t'(wr_data[CTL_LSB +: CTL_W]);
            data_q   <= wr_data[DATA_W-1:0];
        end else if (wr_co) begin
            sw_ctl_q <= ctl_t'(wr_data[CTL_W-1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (port_clr) begin
            irq_q <= 1'b0;
        end else if (periph_evt) begin
            irq_q <= 1'b1;
        end else if (wr_dc && wr_data[ACK_POS]) begin
            irq_q <= 1'b0;
        end
    end

endmodule

// File: rtl/lpt_mode.sv
module lpt_mode
    import lpt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  cfg_t              cfg,
    input  logic              hs_idle,
    output logic [MODE_W-1:0] mode_eff,
    output logic              req_illegal,
    output logic              change_pending
);
    logic [MODE_W-1:0] req;

    assign req            = {cfg.ext, cfg.mode};
    assign req_illegal    = !mode_legal(req);
    assign change_pending = !req_illegal && (req != mode_eff);

    always_ff @(posedge clk) begin
        if (rst || !cfg.en) begin
            mode_eff <= MODE_MANUAL;
        end else if (change_pending && (cfg.force_sw || hs_idle)) begin
            mode_eff <= req;
        end
    end

endmodule

// File: rtl/lpt_pins.sv
module lpt_pins
    import lpt_pkg::*;
(
    input  logic [MODE_W-1:0] mode_eff,
    input  ctl_t              sw_ctl,
    input  logic [CTL_W-1:0]  hs_ctl,
    input  ctl_t              out_inv,
    input  sts_t              in_inv,
    input  sts_t              sts_pins,
    output ctl_t              pin_lvl,
    output sts_t              sts_view
);
    logic [CTL_W-1:0] own;
    logic [CTL_W-1:0] asrt;
    logic [CTL_W-1:0] inv;
    logic [CTL_W-1:0] lvl;
    logic [CTL_W-1:0] off_lvl;

    assign own     = sw_owned(mode_eff);
    assign asrt    = (own & sw_ctl) | (~own & hs_ctl);
    assign inv     = out_inv;
    // Off levels: oe inactive, selectin low, the rest high.
    assign off_lvl = {out_inv.oe, 1'b0, 1'b1, 1'b1, 1'b1};

    for (genvar i = 0; i < CTL_W; i++) begin : g_pin
        if (i == CTL_W - 1) begin : g_oe
            assign lvl[i] = asrt[i] ^ inv[i];
        end else begin : g_lowact
            assign lvl[i] = ~asrt[i] ^ inv[i];
        end
    end

    assign pin_lvl  = ctl_t'((mode_eff == MODE_OFF) ? off_lvl : lvl);
    assign sts_view = sts_pins ^ in_inv;

endmodule

// File: rtl/lpt_ctl_core.sv
module lpt_ctl_core
    import lpt_pkg::*;
#(
    parameter int BUS_W  = 32,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2,
    parameter int STAT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BUS_W-1:0]  wr_data,
    input  logic              hs_idle,
    input  logic [4:0]        hs_ctl,
    input  logic              periph_evt,
    input  logic              perror,
    input  logic              ack_n,
    input  logic              busy,
    input  logic              fault_n,
    input  logic              select,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic              strobe_n,
    output logic              autofd_n,
    output logic              init_n,
    output logic              selectin_n,
    output logic              peri_irq,
    output logic [STAT_W-1:0] status_word
);
    localparam int USED_W = STS_W + MODE_W + 3;

    cfg_t              cfg_q;
    ctl_t              sw_ctl_q;
    logic [MODE_W-1:0] mode_eff;
    logic              req_illegal;
    logic              change_pending;
    ctl_t              pin_lvl;
    sts_t              sts_pins;
    sts_t              sts_view;

    assign sts_pins = '{perr: perror, ackn: ack_n, bsy: busy, flt: fault_n, slct: select};

    lpt_regs #(
        .BUS_W  (BUS_W),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .periph_evt (periph_evt),
        .cfg_q      (cfg_q),
        .sw_ctl_q   (sw_ctl_q),
        .data_q     (data_out),
        .irq_q      (peri_irq)
    );

    lpt_mode u_mode (
        .clk            (clk),
        .rst            (rst),
        .cfg            (cfg_q),
        .hs_idle        (hs_idle),
        .mode_eff       (mode_eff),
        .req_illegal    (req_illegal),
        .change_pending (change_pending)
    );

    lpt_pins u_pins (
        .mode_eff (mode_eff),
        .sw_ctl   (sw_ctl_q),
        .hs_ctl   (hs_ctl),
        .out_inv  (cfg_q.out_inv),
        .in_inv   (cfg_q.in_inv),
        .sts_pins (sts_pins),
        .pin_lvl  (pin_lvl),
        .sts_view (sts_view)
    );

    assign data_oe    = pin_lvl.oe;
    assign selectin_n = pin_lvl.slin;
    assign autofd_n   = pin_lvl.afd;
    assign strobe_n   = pin_lvl.stb;
    assign init_n     = pin_lvl.ini;

    assign status_word = {{(STAT_W-USED_W){1'b0}}, change_pending, peri_irq,
                          req_illegal, mode_eff, sts_view};

endmodule

// File: rtl/lpt_ctl_core_chk.sv
module lpt_ctl_core_chk
    import lpt_pkg::*;
#(
    parameter int BUS_W  = 32,
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [BUS_W-1:0]  wr_data,
    input logic              hs_idle,
    input logic              periph_evt,
    input cfg_t              cfg_q,
    input logic [MODE_W-1:0] mode_eff,
    input logic              peri_irq,
    input logic              strobe_n,
    input logic              autofd_n,
    input logic              init_n,
    input logic              selectin_n
);
    logic [MODE_W-1:0] req;
    assign req = {cfg_q.ext, cfg_q.mode};

    a_r1_disabled_clears: assert property (@(posedge clk) disable iff (rst)
        !cfg_q.en |=> (mode_eff == MODE_MANUAL) && !peri_irq);

    a_r3_defer_while_busy: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.en && !cfg_q.force_sw && !hs_idle) |=> $stable(mode_eff));

    a_r4_force_adopts: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.en && cfg_q.force_sw && mode_legal(req)) |=> (mode_eff == $past(req)));

    a_r5_eff_legal: assert property (@(posedge clk) disable iff (rst)
        mode_legal(mode_eff));

    a_r7_off_levels: assert property (@(posedge clk) disable iff (rst)
        (mode_eff == MODE_OFF) |-> ({selectin_n, autofd_n, strobe_n, init_n} == 4'b0111));

    a_r10_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_addr == ADDR_W'(ADR_DATA_CTL)) && wr_data[16] && !periph_evt)
        |=> !peri_irq);

endmodule

bind lpt_ctl_core lpt_ctl_core_chk #(.BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .hs_idle    (hs_idle),
    .periph_evt (periph_evt),
    .cfg_q      (cfg_q),
    .mode_eff   (mode_eff),
    .peri_irq   (peri_irq),
    .strobe_n   (strobe_n),
    .autofd_n   (autofd_n),
    .init_n     (init_n),
    .selectin_n (selectin_n)
);

// File: tb/tb_lpt_ctl_core.sv
module tb_lpt_ctl_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        hs_idle = 1'b1;
    logic [4:0]  hs_ctl = '0;
    logic        periph_evt = 1'b0;
    logic [4:0]  sts_in = '0;
    logic [7:0]  data_out;
    logic        data_oe, strobe_n, autofd_n, init_n, selectin_n, peri_irq;
    logic [15:0] status_word;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    lpt_ctl_core dut (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .hs_idle     (hs_idle),
        .hs_ctl      (hs_ctl),
        .periph_evt  (periph_evt),
        .perror      (sts_in[4]),
        .ack_n       (sts_in[3]),
        .busy        (sts_in[2]),
        .fault_n     (sts_in[1]),
        .select      (sts_in[0]),
        .data_out    (data_out),
        .data_oe     (data_oe),
        .strobe_n    (strobe_n),
        .autofd_n    (autofd_n),
        .init_n      (init_n),
        .selectin_n  (selectin_n),
        .peri_irq    (peri_irq),
        .status_word (status_word)
    );

    // {sw ctl, out inv, expected pins, status pins, in inv, expected status}
    localparam logic [29:0] VEC [6] = '{
        {5'b00000, 5'b00000, 5'b01111, 5'b10101, 5'b00000, 5'b10101},
        {5'b11111, 5'b00000, 5'b10000, 5'b10101, 5'b11111, 5'b01010},
        {5'b00000, 5'b11111, 5'b10000, 5'b00000, 5'b01100, 5'b01100},
        {5'b11111, 5'b11111, 5'b01111, 5'b11111, 5'b00011, 5'b11100},
        {5'b00101, 5'b00000, 5'b01010, 5'b01110, 5'b10001, 5'b11111},
        {5'b01010, 5'b00110, 5'b00011, 5'b00110, 5'b00110, 5'b00000}
    };

    function automatic logic [31:0] cfgw(input logic [2:0] mode, input logic ext,
                                         input logic frc, input logic en,
                                         input logic [4:0] oinv, input logic [4:0] iinv);
        return {16'b0, iinv, oinv, en, frc, ext, mode};
    endfunction

    function automatic logic [4:0] pins();
        return {data_oe, selectin_n, autofd_n, strobe_n, init_n};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        cyc(3);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 reset mode", 32'(status_word[8:5]), 32'd0);
        check("R1 reset irq", 32'(peri_irq), 32'd0);
        check("R1 reset data", 32'(data_out), 32'd0);
        check("R6 reset pins", 32'(pins()), 32'b01111);

        // Table: manual-mode pin drive (R6) and status inversion (R9)
        for (int k = 0; k < 6; k++) begin
            wr(2'd2, cfgw(3'd0, 1'b0, 1'b1, 1'b1, VEC[k][24:20], VEC[k][9:5]));
            wr(2'd1, 32'(VEC[k][29:25]));
            sts_in = VEC[k][14:10];
            @(negedge clk);
            check("R6 manual pins", 32'(pins()), 32'(VEC[k][19:15]));
            check("R9 status inversion", 32'(status_word[4:0]), 32'(VEC[k][4:0]));
        end

        // R11 control-only write keeps data byte
        wr(2'd2, cfgw(3'd0, 1'b0, 1'b1, 1'b1, 5'b0, 5'b0));
        wr(2'd0, 32'h0000_00A5);
        wr(2'd1, 32'h0000_001F);
        check("R11 data kept", 32'(data_out), 32'hA5);
        check("R11 ctl updated", 32'(pins()), 32'b10000);
        wr(2'd3, 32'h0000_0000);
        check("R11 addr3 ignored", 32'(data_out), 32'hA5);

        // R3 deferral until idle, R12 status shows effective mode
        hs_idle = 1'b0;
        wr(2'd2, cfgw(3'd1, 1'b0, 1'b0, 1'b1, 5'b0, 5'b0));
        cyc(3);
        check("R3 held while busy", 32'(status_word[8:5]), 32'd0);
        check("R12 pending flag", 32'(status_word[11]), 32'd1);
        hs_idle = 1'b1;
        @(negedge clk);
        check("R3 adopted at idle", 32'(status_word[8:5]), 32'd1);
        check("R12 pending cleared", 32'(status_word[11]), 32'd0);

        // R8 engine-owned pins in centronics then nibble
        wr(2'd1, 32'b00101);
        hs_ctl = 5'b11010;
        @(negedge clk);
        check("R8 centronics pins", 32'(pins()), 32'b10000);
        hs_idle = 1'b0;
        wr(2'd2, cfgw(3'd3, 1'b0, 1'b1, 1'b1, 5'b0, 5'b0));
        @(negedge clk);
        check("R4 forced while busy", 32'(status_word[8:5]), 32'd3);
        check("R8 nibble pins", 32'(pins()), 32'b10100);

        // R7 off levels ignore inversion except oe
        wr(2'd2, cfgw(3'd7, 1'b0, 1'b1, 1'b1, 5'b11111, 5'b0));
        @(negedge clk);
        check("R7 off pins", 32'(pins()), 32'b10111);

        // R2 extension modes
        wr(2'd2, cfgw(3'd5, 1'b1, 1'b1, 1'b1, 5'b0, 5'b0));
        @(negedge clk);
        check("R2 epp write1", 32'(status_word[8:5]), 32'd13);
        wr(2'd2, cfgw(3'd0, 1'b1, 1'b1, 1'b1, 5'b0, 5'b0));
        @(negedge clk);
        check("R2 epp read", 32'(status_word[8:5]), 32'd8);

        // R5 illegal request
        wr(2'd2, cfgw(3'd2, 1'b1, 1'b1, 1'b1, 5'b0, 5'b0));
        cyc(2);
        check("R5 illegal flag", 32'(status_word[9]), 32'd1);
        check("R5 not adopted", 32'(status_word[8:5]), 32'd8);
        hs_idle = 1'b1;
        hs_ctl  = '0;

        // R10 interrupt latch
        @(negedge clk);
        periph_evt = 1'b1;
        @(negedge clk);
        periph_evt = 1'b0;
        check("R10 irq set", 32'(peri_irq), 32'd1);
        wr(2'd0, 32'h0000_0011);
        check("R10 ack zero no effect", 32'(status_word[10]), 32'd1);
        wr(2'd0, 32'h0001_0011);
        check("R10 ack clears", 32'(peri_irq), 32'd0);

        // R1 enable cleared holds port in reset
        @(negedge clk);
        periph_evt = 1'b1;
        @(negedge clk);
        periph_evt = 1'b0;
        wr(2'd2, cfgw(3'd5, 1'b1, 1'b1, 1'b0, 5'b0, 5'b0));
        @(negedge clk);
        check("R1 disabled mode", 32'(status_word[8:5]), 32'd0);
        check("R1 disabled irq", 32'(peri_irq), 32'd0);
        check("R1 disabled data", 32'(data_out), 32'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule